// File: doc/BRIEF.md
# Instruction Lead-Byte Classifier

This block sits at the front of an instruction decoder. It takes instruction bytes one at a time, one per clock, over a valid/ready handshake. A start strobe sent with a byte marks it as the first byte of an instruction. That byte is either a branch target or the byte after the previous instruction. The block sorts each following byte into one of four kinds: a legacy prefix, a REX prefix, an escape byte, or the lead byte of a VEX prefix. It keeps sorting until it finds the opcode byte. It then presents one record holding the prefix flags, the REX or VEX payload, the opcode map, the opcode and an invalid flag.

The classification depends on the operating mode, given by `mode`: 0 is real 16-bit, 1 is protected 16-bit, 2 is 32-bit and 3 is 64-bit. The mode decides whether 40h-4Fh are prefixes or opcodes. It also decides whether C4h/C5h start a VEX prefix or are the LES/LDS opcodes. In modes 1 and 2 that choice needs a look at the following byte. After the record is taken, the block waits for the next start strobe.

Top module: `insn_lead_sorter`

## Requirements
- R1: Legacy prefixes are gathered by group, and a repeated group keeps the last value seen.
  - Segment group, on `out_seg`: 2E=1, 36=2, 3E=3, 26=4, 64=5, 65=6.
  - Repeat group, on `out_rep`: F2=1, F3=2.
  - `out_lock` is set by F0, `out_opsz` by 66 and `out_adsz` by 67.
- R2: The first byte that is not a prefix, escape or VEX lead is the opcode, with map 0. `out_valid` rises in the cycle after that byte is accepted.
- R3: After 0F, the next byte is the opcode with map 1, even if its value is a prefix value. After 0F 38 the following byte is the opcode with map 2, and after 0F 3A it is the opcode with map 3.
- R4: In mode 3, bytes 40h-4Fh are REX. They set `out_rex_vld` and place their low nibble on `out_rex`. In every other mode they are opcodes.
- R5: A REX byte followed by a legacy prefix or a VEX prefix is dropped, so `out_rex_vld` is 0.
- R6: In mode 3, C4/C5 always start a VEX prefix and set `out_vex_vld`.
  - C5 is the short form: one payload byte, then the opcode, with map 1.
  - C4 is the long form: two payload bytes, then the opcode. Bits 4:0 of its first payload byte give the map: 1, 2 or 3 map to 1, 2 or 3.
  - Any other value in those bits sets `out_invalid` and gives map 0.
- R7: In modes 1 and 2, C4/C5 start a VEX prefix only when bits 7:6 of the next byte are both 1. Otherwise the record reports opcode C4/C5 with map 0 and no VEX, and that next byte is consumed.
- R8: In mode 0, C4/C5 are always opcodes, and the record follows that single byte.
- R9: When a 15th prefix byte (legacy or REX) arrives before an opcode, the record ends at once with `out_invalid`=1 and opcode 00.
- R10: While `out_valid` is high and `out_ready` is low, the record holds steady and `in_ready` stays low.
- R11: When no instruction is open, bytes that arrive without `in_start` are dropped. A byte that arrives with `in_start` during an instruction discards what was gathered and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Operating mode: 0 real16, 1 prot16, 2 32-bit, 3 64-bit |
| in_valid | input | 1 | Byte valid |
| in_start | input | 1 | Byte is the first byte of an instruction |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte |
| out_ready | input | 1 | Consumer takes the record |
| out_valid | output | 1 | Record available |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat group code |
| out_seg | output | 3 | Segment group code |
| out_opsz | output | 1 | Operand-size prefix seen |
| out_adsz | output | 1 | Address-size prefix seen |
| out_rex_vld | output | 1 | REX in effect |
| out_rex | output | 4 | REX low nibble |
| out_vex_vld | output | 1 | VEX encoded |
| out_vex3 | output | 1 | Long VEX form (C4) |
| out_vex_p0 | output | 8 | First VEX payload byte |
| out_vex_p1 | output | 8 | Second VEX payload byte (long form) |
| out_map | output | 2 | Opcode map: 0 one-byte, 1 0F, 2 0F38, 3 0F3A |
| out_opcode | output | 8 | Opcode byte |
| out_invalid | output | 1 | Prefix overflow or bad VEX map |

## Verification
The same bytes are sent under different modes, so that a single wrong mode test shows up.
- 48h is sent in 32-bit and in 64-bit mode; this separates REX from the one-byte inc/dec opcode.
- C4/C5 are sent in real, protected and 64-bit modes, with follower bytes whose top bits are 11 and 00; this separates a VEX prefix from LES/LDS.
- Escape sequences end in byte values that are also prefix values; this shows that an escape makes the next byte the opcode.
- Runs of 14 and 15 prefixes sit on either side of the overflow limit.
- Repeated groups show that the last value wins, and a REX followed by a legacy prefix shows that the REX is dropped.

// File: rtl/ils_pkg.sv
`timescale 1ns/1ps
package ils_pkg;

  localparam logic [1:0] MODE_REAL = 2'd0;
  localparam logic [1:0] MODE_P16  = 2'd1;
  localparam logic [1:0] MODE_P32  = 2'd2;
  localparam logic [1:0] MODE_LONG = 2'd3;

  typedef enum logic [2:0] {
    BC_OPC, BC_LEG, BC_REX, BC_ESC, BC_VEX
  } byte_cls_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rep;
    logic [2:0] seg;
    logic       opsz;
    logic       adsz;
    logic       rex_vld;
    logic [3:0] rex;
  } pfx_t;

  // Segment-group code of a byte, 0 if it is not a segment override.
  function automatic logic [2:0] f_seg_code(input logic [7:0] b);
    case (b)
      8'h2E:   return 3'd1;
      8'h36:   return 3'd2;
      8'h3E:   return 3'd3;
      8'h26:   return 3'd4;
      8'h64:   return 3'd5;
      8'h65:   return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  // Repeat-group code of a byte, 0 if it is not F2/F3.
  function automatic logic [1:0] f_rep_code(input logic [7:0] b);
    case (b)
      8'hF2:   return 2'd1;
      8'hF3:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  // Map selected by the first payload byte of a long VEX form: {bad, map}.
  function automatic logic [2:0] f_vex_map(input logic [7:0] p0);
    case (p0[4:0])
      5'd1:    return 3'b0_01;
      5'd2:    return 3'b0_10;
      5'd3:    return 3'b0_11;
      default: return 3'b1_00;
    endcase
  endfunction

endpackage

// File: rtl/ils_byte_class.sv
`timescale 1ns/1ps
module ils_byte_class
  import ils_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic [1:0] mode_i,
  output byte_cls_e  cls_o,
  output logic [2:0] seg_o,
  output logic [1:0] rep_o,
  output logic       lock_o,
  output logic       opsz_o,
  output logic       adsz_o
);

  always_comb begin
    seg_o  = f_seg_code(byte_i);
    rep_o  = f_rep_code(byte_i);
    lock_o = (byte_i == 8'hF0);
    opsz_o = (byte_i == 8'h66);
    adsz_o = (byte_i == 8'h67);
    if (seg_o != 3'd0 || rep_o != 2'd0 || lock_o || opsz_o || adsz_o)
      cls_o = BC_LEG;
    else if (byte_i == 8'h0F)
      cls_o = BC_ESC;
    else if (byte_i == 8'hC4 || byte_i == 8'hC5)
      cls_o = (mode_i == MODE_REAL) ? BC_OPC : BC_VEX;
    else if (byte_i[7:4] == 4'h4 && mode_i == MODE_LONG)
      cls_o = BC_REX;
    else
      cls_o = BC_OPC;
  end

endmodule

// File: rtl/ils_prefix_acc.sv
`timescale 1ns/1ps
module ils_prefix_acc
  import ils_pkg::*;
#(
  parameter int MAX_PFX = 14,
  localparam int CW = $clog2(MAX_PFX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       leg_i,
  input  logic       rex_i,
  input  logic       rex_kill_i,
  input  logic [7:0] byte_i,
  input  logic [2:0] seg_i,
  input  logic [1:0] rep_i,
  input  logic       lock_i,
  input  logic       opsz_i,
  input  logic       adsz_i,
  output pfx_t       pfx_o,
  output logic       full_o
);

  pfx_t          pfx_q, base, nxt;
  logic [CW-1:0] cnt_q, cnt_base, cnt_nxt;

  always_comb begin
    base     = clr_i ? '0 : pfx_q;
    cnt_base = clr_i ? '0 : cnt_q;
    nxt      = base;
    cnt_nxt  = cnt_base;
    if (leg_i) begin
      if (seg_i != 3'd0) nxt.seg  = seg_i;
      if (rep_i != 2'd0) nxt.rep  = rep_i;
      if (lock_i)        nxt.lock = 1'b1;
      if (opsz_i)        nxt.opsz = 1'b1;
      if (adsz_i)        nxt.adsz = 1'b1;
      nxt.rex_vld = 1'b0;
    end
    if (rex_kill_i) nxt.rex_vld = 1'b0;
    if (rex_i) begin
      nxt.rex_vld = 1'b1;
      nxt.rex     = byte_i[3:0];
    end
    if (leg_i || rex_i) cnt_nxt = cnt_base + 1'b1;
  end

  assign full_o = (cnt_base == CW'(MAX_PFX));
  assign pfx_o  = pfx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q <= '0;
      cnt_q <= '0;
    end else begin
      pfx_q <= nxt;
      cnt_q <= cnt_nxt;
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_PFX));

endmodule

// File: rtl/insn_lead_sorter.sv
`timescale 1ns/1ps
module insn_lead_sorter
  import ils_pkg::*;
#(
  parameter int MAX_PFX = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       in_valid,
  input  logic       in_start,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  input  logic       out_ready,
  output logic       out_valid,
  output logic       out_lock,
  output logic [1:0] out_rep,
  output logic [2:0] out_seg,
  output logic       out_opsz,
  output logic       out_adsz,
  output logic       out_rex_vld,
  output logic [3:0] out_rex,
  output logic       out_vex_vld,
  output logic       out_vex3,
  output logic [7:0] out_vex_p0,
  output logic [7:0] out_vex_p1,
  output logic [1:0] out_map,
  output logic [7:0] out_opcode,
  output logic       out_invalid
);

  typedef enum logic [3:0] {
    S_IDLE, S_PFX, S_ESC, S_E38, S_E3A, S_VPEEK, S_VB2, S_VOP, S_OUT
  } st_e;

  st_e       state, eff_st, nxt;
  byte_cls_e cls;
  logic [2:0] seg_c;
  logic [1:0] rep_c;
  logic       lock_c, opsz_c, adsz_c;
  pfx_t       pfx;
  logic       full;

  logic       take, first, work;
  logic       leg_hit, rex_hit, vex_hit, vex_lead;
  logic       p1_ld;
  logic       emit_w, emit_inv;
  logic [1:0] emit_map;
  logic [7:0] emit_op;

  logic       vex3_q, vvld_q, vbad_q;
  logic [7:0] p0_q, p1_q;
  logic [1:0] vmap_q;
  logic [7:0] op_q;
  logic [1:0] map_q;
  logic       inv_q;

  assign in_ready  = (state != S_OUT);
  assign out_valid = (state == S_OUT);
  assign take      = in_valid && in_ready;
  assign first     = take && in_start;
  assign eff_st    = first ? S_PFX : state;
  assign work      = take && (eff_st != S_IDLE);

  ils_byte_class u_cls (
    .byte_i (in_byte), .mode_i (mode), .cls_o (cls),
    .seg_o (seg_c), .rep_o (rep_c), .lock_o (lock_c),
    .opsz_o (opsz_c), .adsz_o (adsz_c)
  );

  ils_prefix_acc #(.MAX_PFX(MAX_PFX)) u_acc (
    .clk (clk), .rst_n (rst_n), .clr_i (first),
    .leg_i (leg_hit), .rex_i (rex_hit), .rex_kill_i (vex_hit),
    .byte_i (in_byte), .seg_i (seg_c), .rep_i (rep_c),
    .lock_i (lock_c), .opsz_i (opsz_c), .adsz_i (adsz_c),
    .pfx_o (pfx), .full_o (full)
  );

  // Sequencing of prefix, escape, VEX and opcode bytes.
  always_comb begin
    nxt      = eff_st;
    leg_hit  = 1'b0;
    rex_hit  = 1'b0;
    vex_hit  = 1'b0;
    vex_lead = 1'b0;
    p1_ld    = 1'b0;
    emit_w   = 1'b0;
    emit_inv = 1'b0;
    emit_map = 2'd0;
    emit_op  = in_byte;
    if (state == S_OUT) begin
      if (out_ready) nxt = S_IDLE;
    end else if (work) begin
      case (eff_st)
        S_PFX: begin
          case (cls)
            BC_LEG, BC_REX: begin
              if (full) begin
                emit_w   = 1'b1;
                emit_inv = 1'b1;
                emit_op  = 8'h00;
              end else if (cls == BC_LEG) begin
                leg_hit = 1'b1;
              end else begin
                rex_hit = 1'b1;
              end
            end
            BC_ESC:  nxt = S_ESC;
            BC_VEX: begin
              vex_lead = 1'b1;
              nxt      = S_VPEEK;
            end
            default: emit_w = 1'b1;
          endcase
        end
        S_ESC: begin
          if (in_byte == 8'h38)      nxt = S_E38;
          else if (in_byte == 8'h3A) nxt = S_E3A;
          else begin
            emit_w   = 1'b1;
            emit_map = 2'd1;
          end
        end
        S_E38: begin
          emit_w   = 1'b1;
          emit_map = 2'd2;
        end
        S_E3A: begin
          emit_w   = 1'b1;
          emit_map = 2'd3;
        end
        S_VPEEK: begin
          if (mode == MODE_LONG || in_byte[7:6] == 2'b11) begin
            vex_hit = 1'b1;
            nxt     = vex3_q ? S_VB2 : S_VOP;
          end else begin
            emit_w  = 1'b1;
            emit_op = vex3_q ? 8'hC4 : 8'hC5;
          end
        end
        S_VB2: begin
          p1_ld = 1'b1;
          nxt   = S_VOP;
        end
        S_VOP: begin
          emit_w   = 1'b1;
          emit_map = vmap_q;
          emit_inv = vbad_q;
        end
        default: nxt = eff_st;
      endcase
    end
    if (emit_w) nxt = S_OUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      vex3_q <= 1'b0;
      vvld_q <= 1'b0;
      vbad_q <= 1'b0;
      p0_q   <= '0;
      p1_q   <= '0;
      vmap_q <= '0;
      op_q   <= '0;
      map_q  <= '0;
      inv_q  <= 1'b0;
    end else begin
      state <= nxt;
      if (first) begin
        vvld_q <= 1'b0;
        vbad_q <= 1'b0;
        p0_q   <= '0;
        p1_q   <= '0;
        vmap_q <= '0;
        vex3_q <= 1'b0;
      end
      if (vex_lead) vex3_q <= (in_byte == 8'hC4);
      if (vex_hit) begin
        vvld_q <= 1'b1;
        p0_q   <= in_byte;
        if (vex3_q) begin
          vmap_q <= f_vex_map(in_byte)[1:0];
          vbad_q <= f_vex_map(in_byte)[2];
        end else begin
          vmap_q <= 2'd1;
          vbad_q <= 1'b0;
        end
      end
      if (p1_ld) p1_q <= in_byte;
      if (emit_w) begin
        op_q  <= emit_op;
        map_q <= emit_map;
        inv_q <= emit_inv;
      end
    end
  end

  assign out_lock    = pfx.lock;
  assign out_rep     = pfx.rep;
  assign out_seg     = pfx.seg;
  assign out_opsz    = pfx.opsz;
  assign out_adsz    = pfx.adsz;
  assign out_rex_vld = pfx.rex_vld;
  assign out_rex     = pfx.rex;
  assign out_vex_vld = vvld_q;
  assign out_vex3    = vex3_q;
  assign out_vex_p0  = p0_q;
  assign out_vex_p1  = p1_q;
  assign out_map     = map_q;
  assign out_opcode  = op_q;
  assign out_invalid = inv_q;

  // R2
  emit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit_w |=> out_valid);

  // R10
  hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_map)
                                && $stable(out_invalid));

  // R10
  no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R6
  vex2_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_vex_vld && !out_vex3 |-> out_map == 2'd1);

  // R5
  rex_vex_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_rex_vld && out_vex_vld));

endmodule

// File: tb/insn_lead_sorter_tb.sv
`timescale 1ns/1ps
module insn_lead_sorter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd2;
  logic       in_valid = 1'b0, in_start = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, out_valid, out_lock, out_opsz, out_adsz, out_rex_vld;
  logic       out_vex_vld, out_vex3, out_invalid;
  logic [1:0] out_rep, out_map;
  logic [2:0] out_seg;
  logic [3:0] out_rex;
  logic [7:0] out_vex_p0, out_vex_p1, out_opcode;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  insn_lead_sorter dut_i (
    .clk (clk), .rst_n (rst_n), .mode (mode), .in_valid (in_valid),
    .in_start (in_start), .in_byte (in_byte), .in_ready (in_ready),
    .out_ready (out_ready), .out_valid (out_valid), .out_lock (out_lock),
    .out_rep (out_rep), .out_seg (out_seg), .out_opsz (out_opsz),
    .out_adsz (out_adsz), .out_rex_vld (out_rex_vld), .out_rex (out_rex),
    .out_vex_vld (out_vex_vld), .out_vex3 (out_vex3),
    .out_vex_p0 (out_vex_p0), .out_vex_p1 (out_vex_p1),
    .out_map (out_map), .out_opcode (out_opcode), .out_invalid (out_invalid)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [2:0]  n;
    logic [39:0] b;     // first byte in the top 8 bits
    logic [7:0]  op;
    logic [1:0]  map;
    logic        vex;
    logic [1:0]  rep;
    logic [2:0]  seg;
    logic        rexv;
    logic        opsz;
    logic        lock;
    logic        inv;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 3'd1, 40'h90_00000000, 8'h90, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
    '{2'd2, 3'd4, 40'h66F30FB8_00, 8'hB8, 2'd1, 1'b0, 2'd2, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 R3
    '{2'd2, 3'd2, 40'h0FF2_000000, 8'hF2, 2'd1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd2, 3'd3, 40'h0F3800_0000, 8'h00, 2'd2, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd3, 3'd3, 40'h0F3A0F_0000, 8'h0F, 2'd3, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3
    '{2'd3, 3'd2, 40'h4889_000000, 8'h89, 2'd0, 1'b0, 2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    '{2'd2, 3'd1, 40'h48_00000000, 8'h48, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{2'd3, 3'd3, 40'h486689_0000, 8'h89, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    '{2'd3, 3'd3, 40'hC5F877_0000, 8'h77, 2'd1, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{2'd2, 3'd3, 40'hC5F877_0000, 8'h77, 2'd1, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{2'd2, 3'd2, 40'hC406_000000, 8'hC4, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{2'd0, 3'd1, 40'hC5_00000000, 8'hC5, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{2'd1, 3'd4, 40'hC4E27918_00, 8'h18, 2'd2, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
    '{2'd3, 3'd4, 40'hC4027918_00, 8'h18, 2'd2, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{2'd3, 3'd4, 40'hC4057918_00, 8'h18, 2'd0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6
    '{2'd2, 3'd5, 40'hF2F32E3690,  8'h90, 2'd0, 1'b0, 2'd2, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
    '{2'd1, 3'd3, 40'hF06490_0000, 8'h90, 2'd0, 1'b0, 2'd0, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0}  // R1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] m, input logic [7:0] b, input logic st);
    @(negedge clk);
    mode = m; in_valid = 1'b1; in_byte = b; in_start = st;
    @(posedge clk);
  endtask

  task automatic stop_in();
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
  endtask

  task automatic pop();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset out_valid", 32'(out_valid), 32'd0);
    chk("R10 reset in_ready", 32'(in_ready), 32'd1);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VECS[v].n); i++)
        push(VECS[v].m, VECS[v].b[39-8*i -: 8], i == 0);
      stop_in();
      chk($sformatf("R2 valid vec%0d", v),  32'(out_valid),   32'd1);
      chk($sformatf("R2 opcode vec%0d", v), 32'(out_opcode),  32'(VECS[v].op));
      chk($sformatf("R3 map vec%0d", v),    32'(out_map),     32'(VECS[v].map));
      chk($sformatf("R6 vex vec%0d", v),    32'(out_vex_vld), 32'(VECS[v].vex));
      chk($sformatf("R1 rep vec%0d", v),    32'(out_rep),     32'(VECS[v].rep));
      chk($sformatf("R1 seg vec%0d", v),    32'(out_seg),     32'(VECS[v].seg));
      chk($sformatf("R4 rex vec%0d", v),    32'(out_rex_vld), 32'(VECS[v].rexv));
      chk($sformatf("R1 opsz vec%0d", v),   32'(out_opsz),    32'(VECS[v].opsz));
      chk($sformatf("R1 lock vec%0d", v),   32'(out_lock),    32'(VECS[v].lock));
      chk($sformatf("R9 inv vec%0d", v),    32'(out_invalid), 32'(VECS[v].inv));
      pop();
    end

    // R4 REX payload nibble
    push(2'd3, 8'h4D, 1'b1); push(2'd3, 8'h01, 1'b0); stop_in();
    chk("R4 rex nibble", 32'(out_rex), 32'h0D);
    pop();

    // R7 peeked byte consumed: a following non-start byte must not open a record
    push(2'd2, 8'hC4, 1'b1); push(2'd2, 8'h06, 1'b0); stop_in();
    pop();
    push(2'd2, 8'h90, 1'b0); stop_in();
    chk("R7 follower dropped", 32'(out_valid), 32'd0);

    // R11 bytes without start while idle are ignored
    push(2'd2, 8'h90, 1'b0); push(2'd2, 8'h66, 1'b0); stop_in();
    chk("R11 idle ignore", 32'(out_valid), 32'd0);
    // R11 restart mid-instruction
    push(2'd2, 8'h66, 1'b1); push(2'd2, 8'h90, 1'b1); stop_in();
    chk("R11 restart opcode", 32'(out_opcode), 32'h90);
    chk("R11 restart opsz cleared", 32'(out_opsz), 32'd0);

    // R10 hold while out_ready is low
    repeat (3) @(negedge clk);
    chk("R10 hold valid", 32'(out_valid), 32'd1);
    chk("R10 hold ready low", 32'(in_ready), 32'd0);
    chk("R10 hold opcode", 32'(out_opcode), 32'h90);
    pop();
    chk("R10 released", 32'(out_valid), 32'd0);

    // R9 fourteen prefixes are accepted
    for (int k = 0; k < 14; k++) push(2'd2, 8'h3E, k == 0);
    push(2'd2, 8'h90, 1'b0); stop_in();
    chk("R9 14 pfx inv", 32'(out_invalid), 32'd0);
    chk("R9 14 pfx opcode", 32'(out_opcode), 32'h90);
    chk("R1 14 pfx seg", 32'(out_seg), 32'd3);
    pop();

    // R9 the fifteenth prefix ends the record
    for (int k = 0; k < 15; k++) push(2'd2, 8'h3E, k == 0);
    stop_in();
    chk("R9 15 pfx valid", 32'(out_valid), 32'd1);
    chk("R9 15 pfx inv", 32'(out_invalid), 32'd1);
    chk("R9 15 pfx opcode", 32'(out_opcode), 32'h00);
    pop();

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule